// File: doc/BRIEF.md
# Parallel Host Port Register Interface

This block is the slave side of a display controller's parallel host port. A host drives a register-select line, a read/write line and an enable strobe, and moves bytes over an 8-line data bus. The block assembles each transfer and hands accepted command bytes to the instruction decoder. It also keeps the data register and the 7-bit address counter that points into display memory. A status read returns the busy flag together with the live address counter. Data accesses go to display memory through a request/acknowledge port and step the counter afterwards.

A single command bit selects the bus width. In the 8-bit width each enable pulse carries a whole byte. In the 4-bit width only the upper four lines are used, and each byte takes two enable pulses, high nibble first. A sequencer with four states (S_IDLE, S_STORE, S_HOLD, S_FETCH) marks the block busy while it works. Its transitions are:

- S_IDLE to S_HOLD on an accepted command.
- S_IDLE to S_STORE on an accepted data write.
- S_IDLE to S_FETCH on an accepted data read.
- S_STORE to S_HOLD when memory acknowledges.
- S_HOLD to S_FETCH (an address load is pending) or to S_IDLE (nothing pending) when the hold count runs out.
- S_FETCH to S_IDLE when memory acknowledges.

Top module: `hb_regif`

## Requirements
- R1: A transfer completes on the falling edge of the enable strobe. Its meaning is set by select/read-write: select 0 with write is a command, select 0 with read is a status read, select 1 with write is a data write, and select 1 with read is a data read.
- R2: A status read returns the busy flag in bit 7 and the address counter in bits 6..0. The bus is driven only while enable is high and read/write is 1.
- R3: After an accepted command, busy reads 1 for exactly BUSY_CYCLES clocks, counted from the clock edge that completes the transfer. A data write keeps busy high until memory acknowledges, and then for BUSY_CYCLES more clocks.
- R4: A command or data write that completes while busy is 1 is dropped. It changes neither the counter, nor memory, nor the command output.
- R5: A command with bit 7 = 1 loads the address counter from bits 6..0. The data register is then refreshed from memory at the new address once the hold ends.
- R6: A data write stores the byte to memory at the current address and then steps the counter.
- R7: A data read returns the data register. The counter then steps, and the data register is refilled from memory at the new address.
- R8: A command of the form 000001d? sets the step direction: d = 1 counts up, d = 0 counts down. The direction is up after reset. The counter wraps modulo 128 in both directions.
- R9: A command of the form 001w???? sets the bus width: w = 1 selects 8-bit, w = 0 selects 4-bit. The width is 8-bit after reset.
- R10: In 4-bit width each byte is two transfers on lines 7..4, high nibble first. Reads return the high nibble and then the low nibble on lines 7..4, with lines 3..0 at zero. The nibble phase is cleared by reset and by an accepted width command.
- R11: After reset the counter is 0, busy is 0, no memory request is raised, and the bus is not driven.
- R12: Each accepted command is presented on instr_q with a one-clock instr_stb pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| en_i | input | 1 | Host enable strobe; a transfer completes when it falls |
| rs_i | input | 1 | Register select: 0 selects command/status, 1 selects data |
| rw_i | input | 1 | 1 = read, 0 = write |
| bus_i | input | 8 | Data from the host |
| bus_o | output | 8 | Data to the host |
| bus_oe | output | 1 | Drive enable for bus_o |
| instr_stb | output | 1 | One-clock pulse for each accepted command |
| instr_q | output | 8 | Last accepted command byte |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 7 | Memory address (the address counter) |
| mem_wdata | output | 8 | Write data (the data register) |
| mem_rdata | input | 8 | Read data, taken when acknowledged |
| mem_ack | input | 1 | Memory acknowledge |

## Verification
The bench builds the block with BUSY_CYCLES = 16. This value is long enough that two back-to-back host transfers both land inside one busy window, so the drop rule can be exercised on a command and on a data write. It is also short enough that the exact busy length can be counted clock by clock, with a status read held open. Both widths and both counting directions are covered. Wrap-around is reached from both ends of the 7-bit counter, 0 down to 127 and 127 up to 0.

// File: rtl/hb_pkg.sv
package hb_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        S_IDLE,
        S_STORE,
        S_HOLD,
        S_FETCH
    } hb_state_e;

    // command 001w_xxxx : bus width
    function automatic logic is_width_cmd(logic [BYTE_W-1:0] w);
        return w[7:5] == 3'b001;
    endfunction

    // command 0000_01dx : step direction
    function automatic logic is_dir_cmd(logic [BYTE_W-1:0] w);
        return w[7:2] == 6'b000001;
    endfunction

    // command 1aaa_aaaa : load address
    function automatic logic is_addr_cmd(logic [BYTE_W-1:0] w);
        return w[7];
    endfunction

endpackage

// File: rtl/hb_strobe.sv
module hb_strobe
    import hb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              rs_i,
    input  logic              rw_i,
    input  logic [BYTE_W-1:0] bus_i,
    input  logic              wide,
    input  logic              clr_phase,
    output logic              done,
    output logic [BYTE_W-1:0] word,
    output logic              w_rs,
    output logic              w_rw,
    output logic              phase
);
    localparam int NIB_W = BYTE_W / 2;

    logic              en_d;
    logic              fall;
    logic [BYTE_W-1:0] cap;
    logic [NIB_W-1:0]  hi;

    // Bus and controls are captured while enable is high, so the
    // falling edge needs no hold time on the host side.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_d  <= 1'b0;
            cap   <= '0;
            w_rs  <= 1'b0;
            w_rw  <= 1'b0;
            hi    <= '0;
            phase <= 1'b0;
        end else begin
            en_d <= en_i;
            if (en_i) begin
                cap  <= bus_i;
                w_rs <= rs_i;
                w_rw <= rw_i;
            end
            if (clr_phase) begin
                phase <= 1'b0;
            end else if (fall && !wide) begin
                phase <= ~phase;
                if (!phase) hi <= cap[BYTE_W-1:NIB_W];
            end
        end
    end

    assign fall = en_d & ~en_i;
    assign done = fall & (wide | phase);
    assign word = wide ? cap : {hi, cap[BYTE_W-1:NIB_W]};

endmodule

// File: rtl/hb_addr_ctr.sv
module hb_addr_ctr #(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [AW-1:0] ld_val,
    input  logic          step,
    input  logic          up,
    output logic [AW-1:0] ac
);
    // natural wrap modulo 2**AW in both directions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    ac <= '0;
        else if (ld)   ac <= ld_val;
        else if (step) ac <= up ? ac + 1'b1 : ac - 1'b1;
    end
endmodule

// File: rtl/hb_regif.sv
module hb_regif
    import hb_pkg::*;
#(
    parameter int AC_W        = 7,
    parameter int BUSY_CYCLES = 72
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              rs_i,
    input  logic              rw_i,
    input  logic [BYTE_W-1:0] bus_i,
    output logic [BYTE_W-1:0] bus_o,
    output logic              bus_oe,
    output logic              instr_stb,
    output logic [BYTE_W-1:0] instr_q,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AC_W-1:0]   mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    localparam int CW   = $clog2(BUSY_CYCLES + 1);
    localparam int NIB  = BYTE_W / 2;

    hb_state_e         state, nstate;
    logic [CW-1:0]     cnt;
    logic              pend;
    logic [BYTE_W-1:0] dr;
    logic              wide, up, busy;
    logic              xfer_done, w_rs, w_rw, phase;
    logic [BYTE_W-1:0] word;
    logic              cmd_ok, dwr_ok, drd_ok, clr_phase;
    logic [AC_W-1:0]   ac;
    logic [BYTE_W-1:0] rd_val;

    hb_strobe u_strobe (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .rs_i(rs_i), .rw_i(rw_i),
        .bus_i(bus_i), .wide(wide), .clr_phase(clr_phase),
        .done(xfer_done), .word(word), .w_rs(w_rs), .w_rw(w_rw), .phase(phase)
    );

    assign busy      = (state != S_IDLE);
    assign cmd_ok    = xfer_done & ~w_rw & ~w_rs & ~busy;
    assign dwr_ok    = xfer_done & ~w_rw &  w_rs & ~busy;
    assign drd_ok    = xfer_done &  w_rw &  w_rs & ~busy;
    assign clr_phase = cmd_ok & is_width_cmd(word);

    hb_addr_ctr #(.AW(AC_W)) u_ac (
        .clk(clk), .rst_n(rst_n),
        .ld(cmd_ok & is_addr_cmd(word)), .ld_val(word[AC_W-1:0]),
        .step(drd_ok | ((state == S_STORE) & mem_ack)),
        .up(up), .ac(ac)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nstate;
    end

    // next state
    always_comb begin
        nstate = state;
        unique case (state)
            S_IDLE: begin
                if (cmd_ok)      nstate = S_HOLD;
                else if (dwr_ok) nstate = S_STORE;
                else if (drd_ok) nstate = S_FETCH;
            end
            S_STORE: if (mem_ack) nstate = S_HOLD;
            S_HOLD:  if (cnt == '0) nstate = pend ? S_FETCH : S_IDLE;
            S_FETCH: if (mem_ack) nstate = S_IDLE;
            default: nstate = S_IDLE;
        endcase
    end

    // outputs of the sequencer
    always_comb begin
        mem_req = 1'b0;
        mem_we  = 1'b0;
        unique case (state)
            S_STORE: begin mem_req = 1'b1; mem_we = 1'b1; end
            S_FETCH: mem_req = 1'b1;
            default: ;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            pend      <= 1'b0;
            dr        <= '0;
            wide      <= 1'b1;
            up        <= 1'b1;
            instr_stb <= 1'b0;
            instr_q   <= '0;
        end else begin
            if (nstate == S_HOLD && state != S_HOLD)
                cnt <= CW'(BUSY_CYCLES - 1);
            else if (state == S_HOLD && cnt != '0)
                cnt <= cnt - 1'b1;

            if (cmd_ok && is_addr_cmd(word))         pend <= 1'b1;
            else if (state == S_HOLD && cnt == '0)   pend <= 1'b0;

            if (dwr_ok)                              dr <= word;
            else if (state == S_FETCH && mem_ack)    dr <= mem_rdata;

            if (cmd_ok && is_width_cmd(word)) wide <= word[4];
            if (cmd_ok && is_dir_cmd(word))   up   <= word[1];

            instr_stb <= cmd_ok;
            if (cmd_ok) instr_q <= word;
        end
    end

    assign mem_addr  = ac;
    assign mem_wdata = dr;

    // read return: live select line picks status or data register
    assign rd_val = rs_i ? dr : {busy, ac};
    assign bus_o  = wide ? rd_val
                         : {(phase ? rd_val[NIB-1:0] : rd_val[BYTE_W-1:NIB]), {NIB{1'b0}}};
    assign bus_oe = en_i & rw_i;

endmodule

// File: rtl/hb_regif_chk.sv
module hb_regif_chk #(
    parameter int AW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          instr_stb,
    input logic          busy,
    input logic          mem_req,
    input logic          mem_ack,
    input logic [AW-1:0] mem_addr,
    input logic          done,
    input logic          wide,
    input logic [7:0]    bus_o
);
    a_r12_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
        instr_stb |=> !instr_stb);

    a_r3_stb_busy: assert property (@(posedge clk) disable iff (!rst_n)
        instr_stb |-> busy);

    a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    a_r8_ac_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !mem_ack) |=> $stable(mem_addr));

    a_r9_width_by_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wide) |-> instr_stb);

    a_r10_low_lines_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !wide |-> (bus_o[3:0] == 4'h0));
endmodule

bind hb_regif hb_regif_chk #(.AW(AC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .instr_stb(instr_stb), .busy(busy),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
    .done(xfer_done), .wide(wide), .bus_o(bus_o)
);

// File: tb/hb_regif_bench.sv
module hb_regif_bench;
    localparam int BUSY = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_i = 1'b0, rs_i = 1'b0, rw_i = 1'b0;
    logic [7:0] bus_i = '0;
    logic [7:0] bus_o, instr_q, mem_wdata, mem_rdata;
    logic       bus_oe, instr_stb, mem_req, mem_we, mem_ack;
    logic [6:0] mem_addr;
    logic [7:0] mem [128];

    int n_chk = 0, n_fail = 0, stb_cnt = 0;
    bit nib = 1'b0;

    always #5 clk = ~clk;

    hb_regif #(.AC_W(7), .BUSY_CYCLES(BUSY)) u_hb_regif (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .rs_i(rs_i), .rw_i(rw_i),
        .bus_i(bus_i), .bus_o(bus_o), .bus_oe(bus_oe),
        .instr_stb(instr_stb), .instr_q(instr_q),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    // memory model: acknowledge one clock after request
    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            for (int i = 0; i < 128; i++) mem[i] <= 8'(i * 3 + 1);
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_ack && mem_we) mem[mem_addr] <= mem_wdata;
        end
    end

    always @(posedge clk) if (rst_n && instr_stb) stb_cnt++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic xfer8(input bit rs, input bit rw, input logic [7:0] d,
                         output logic [7:0] q);
        @(negedge clk);
        rs_i = rs; rw_i = rw; bus_i = d; en_i = 1'b1;
        repeat (2) @(negedge clk);
        q = bus_o;
        en_i = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic xfer4w(input bit rs, input logic [7:0] d);
        logic [7:0] q;
        xfer8(rs, 1'b0, {d[7:4], 4'h0}, q);
        xfer8(rs, 1'b0, {d[3:0], 4'h0}, q);
    endtask

    task automatic xfer4r(input bit rs, output logic [7:0] v);
        logic [7:0] a, b;
        xfer8(rs, 1'b1, 8'h00, a);
        xfer8(rs, 1'b1, 8'h00, b);
        chk(a[3:0] == 4'h0 && b[3:0] == 4'h0, "R10 low lines", {a[3:0], b[3:0]}, 0);
        v = {a[7:4], b[7:4]};
    endtask

    task automatic status(output logic [7:0] s);
        if (nib) xfer4r(1'b0, s);
        else     xfer8(1'b0, 1'b1, 8'h00, s);
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int k = 0; k < 100; k++) begin
            status(s);
            if (!s[7]) return;
        end
        chk(1'b0, "R3 busy never cleared", 1, 0);
    endtask

    // {rs, rw, compare, data, expected}
    localparam logic [18:0] VEC [18] = '{
        {1'b0, 1'b0, 1'b0, 8'h85, 8'h00},  // R5 load address 5
        {1'b1, 1'b0, 1'b0, 8'hAA, 8'h00},  // R6 store
        {1'b1, 1'b0, 1'b0, 8'h55, 8'h00},
        {1'b0, 1'b1, 1'b1, 8'h00, 8'h07},  // R2 status
        {1'b0, 1'b0, 1'b0, 8'h85, 8'h00},
        {1'b1, 1'b1, 1'b1, 8'h00, 8'hAA},  // R7 read
        {1'b1, 1'b1, 1'b1, 8'h00, 8'h55},
        {1'b0, 1'b1, 1'b1, 8'h00, 8'h07},
        {1'b0, 1'b0, 1'b0, 8'h04, 8'h00},  // R8 count down
        {1'b0, 1'b0, 1'b0, 8'h80, 8'h00},
        {1'b1, 1'b0, 1'b0, 8'h3C, 8'h00},
        {1'b0, 1'b1, 1'b1, 8'h00, 8'h7F},  // R8 wrap 0 -> 127
        {1'b0, 1'b0, 1'b0, 8'h06, 8'h00},  // count up
        {1'b0, 1'b0, 1'b0, 8'hFF, 8'h00},
        {1'b1, 1'b0, 1'b0, 8'h11, 8'h00},
        {1'b0, 1'b1, 1'b1, 8'h00, 8'h00},  // R8 wrap 127 -> 0
        {1'b0, 1'b0, 1'b0, 8'h80, 8'h00},
        {1'b1, 1'b1, 1'b1, 8'h00, 8'h3C}
    };

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] q;
        int busy_n, stb0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk(bus_oe == 1'b0, "R11 bus idle", bus_oe, 0);
        chk(mem_req == 1'b0, "R11 no request", mem_req, 0);
        xfer8(1'b0, 1'b1, 8'h00, q);
        chk(q == 8'h00, "R11 status after reset", q, 0);

        // R2 no drive on write
        @(negedge clk);
        rs_i = 1'b0; rw_i = 1'b0; en_i = 1'b1;
        @(negedge clk);
        chk(bus_oe == 1'b0, "R2 no drive on write", bus_oe, 0);
        en_i = 1'b0;
        repeat (2) @(negedge clk);
        wait_idle();

        // R3 exact busy length, status read held open
        @(negedge clk);
        rs_i = 1'b0; rw_i = 1'b0; bus_i = 8'h06; en_i = 1'b1;
        repeat (2) @(negedge clk);
        en_i = 1'b0;
        @(negedge clk);
        rw_i = 1'b1; en_i = 1'b1;
        busy_n = 0;
        for (int k = 0; k < 40; k++) begin
            #1;
            if (bus_o[7]) busy_n++;
            @(negedge clk);
        end
        en_i = 1'b0;
        repeat (2) @(negedge clk);
        chk(busy_n == BUSY, "R3 busy length", busy_n, BUSY);
        chk(instr_q == 8'h06, "R12 command output", instr_q, 8'h06);

        // R1 main vector walk
        foreach (VEC[i]) begin
            xfer8(VEC[i][18], VEC[i][17], VEC[i][15:8], q);
            if (VEC[i][16])
                chk(q == VEC[i][7:0], $sformatf("R1 vector %0d", i), q, VEC[i][7:0]);
            wait_idle();
        end
        chk(mem[5] == 8'hAA && mem[6] == 8'h55, "R6 memory contents", mem[5], 8'hAA);
        chk(mem[127] == 8'h11, "R6 store at 127", mem[127], 8'h11);

        // R4 writes dropped while busy
        stb0 = stb_cnt;
        xfer8(1'b0, 1'b0, 8'h90, q);
        xfer8(1'b1, 1'b0, 8'h77, q);
        xfer8(1'b0, 1'b0, 8'hA0, q);
        wait_idle();
        status(q);
        chk(q == 8'h10, "R4 counter untouched", q, 8'h10);
        chk(mem[16] == 8'h31, "R4 memory untouched", mem[16], 8'h31);
        chk(stb_cnt - stb0 == 1, "R12 one strobe", stb_cnt - stb0, 1);
        chk(instr_q == 8'h90, "R12 last command", instr_q, 8'h90);
        xfer8(1'b1, 1'b1, 8'h00, q);
        chk(q == 8'h31, "R5 prefetch", q, 8'h31);
        wait_idle();

        // R9 / R10 nibble mode
        xfer8(1'b0, 1'b0, 8'h20, q);
        nib = 1'b1;
        wait_idle();
        xfer4w(1'b0, 8'h83);
        wait_idle();
        xfer4w(1'b1, 8'h9C);
        wait_idle();
        chk(mem[3] == 8'h9C, "R10 nibble write", mem[3], 8'h9C);
        status(q);
        chk(q == 8'h04, "R10 nibble status", q, 8'h04);
        xfer4w(1'b0, 8'h83);
        wait_idle();
        xfer4r(1'b1, q);
        chk(q == 8'h9C, "R10 nibble read order", q, 8'h9C);
        wait_idle();
        xfer4w(1'b0, 8'h30);
        nib = 1'b0;
        wait_idle();
        xfer8(1'b0, 1'b1, 8'h00, q);
        chk(q == 8'h04, "R9 back to 8-bit", q, 8'h04);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule